// File: doc/BRIEF.md
# 4:2:2 Byte-Serial Pixel Demultiplexer

This block sits at the front of a video encoder. It accepts a byte-serial 4:2:2 YCbCr stream carried on an 8-bit bus at twice the luma sample rate. A line starts at each falling edge of the active-low horizontal sync. The block separates the bytes into luma and two chroma components and limits each component to its legal range. It removes the 128 offset from the chroma, so chroma leaves as a signed value. It then fills in the chroma at odd luma positions by interpolation, so that every output sample carries its own Y, Cb and Cr. One output sample appears for every two input bytes, marked by a single-cycle valid strobe.

Two control inputs reorder the byte sequence for sources that use a different packing. One exchanges the two chroma components. The other exchanges the luma and chroma slots. A third input replaces the captured pixels with an internally generated pattern of eight vertical colour bars. The bar pattern passes through the same chroma path as live video, so a downstream stage cannot tell it apart from captured data.

Top module: `ycc422_demux`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_valid` is low and `out_y`, `out_cb`, `out_cr` are zero.
- R2: A line begins when `hsync_n` is sampled high on one clock and low on the next. The byte on the following clock is byte 0. A line holds 2×ACTIVE_PIX bytes. Bytes after the last one are ignored, and holding `hsync_n` low does not start another line.
- R3: With both swaps low, the bytes in each group of four at positions 0,1,2,3 are Cb, Y(even), Cr, Y(odd).
- R4: With `cb_cr_swap` high, the chroma in position 0 is taken as Cr and the chroma in position 2 as Cb (or, with the luma/chroma swap, positions 1 and 3).
- R5: With `luma_chroma_swap` high, positions 0 and 2 carry Y(even) and Y(odd), and positions 1 and 3 carry Cb and Cr (subject to R4).
- R6: A captured luma byte below 16 becomes 16, and one above 235 becomes 235. Other values pass unchanged.
- R7: A captured chroma byte below 16 becomes 16, and one above 240 becomes 240. The chroma output is that value minus 128, as 9-bit two's complement.
- R8: Output sample 2g carries the chroma of group g. Sample 2g+1 carries floor((Cg+Cg+1+1)/2) of the clamped chroma of groups g and g+1 before the offset is removed. The last group of a line uses its own chroma in place of group g+1.
- R9: Each line yields exactly ACTIVE_PIX samples in order. Each sample is marked by `out_valid` high for one cycle, and `out_valid` is never high on two consecutive cycles.
- R10: With `bar_mode` high, the input bytes are ignored. Sample s takes bar k = s/(ACTIVE_PIX/8), and bars 0..7 are (Y,Cb,Cr) = (235,128,128), (162,44,142), (131,156,44), (112,72,58), (84,184,198), (65,100,212), (35,212,114), (16,128,128). Chroma is then interpolated per R8.
- R11: Whenever `out_valid` is high, `out_y` lies in 16..235 and `out_cb`, `out_cr` lie in −112..112.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, two bytes per output sample |
| rst | input | 1 | Synchronous active-high reset |
| hsync_n | input | 1 | Active-low horizontal sync; falling edge starts a line |
| pix_in | input | 8 | Byte-serial 4:2:2 pixel data |
| cb_cr_swap | input | 1 | Exchange the two chroma slots |
| luma_chroma_swap | input | 1 | Exchange luma and chroma slots |
| bar_mode | input | 1 | Replace input pixels with the colour-bar pattern |
| out_valid | output | 1 | One-cycle strobe per output sample |
| out_y | output | 8 | Clamped luma |
| out_cb | output | 9 | Signed blue-difference chroma |
| out_cr | output | 9 | Signed red-difference chroma |

## Verification
The hardest case to reach is the interpolated chroma on the last odd sample of a line. It has no following group, and it leaves the block through a delayed flush after the input has gone quiet. Each line ends by driving extra bytes with `hsync_n` still low. This proves that those bytes never produce a sample and that the flushed sample still carries its own chroma. Every byte value from 0 to 255 is sent into both a luma slot and a chroma slot under all four swap settings. The bar lines are sent with garbage bytes on the bus, so the averaging across each bar boundary is compared against the bench's own table.

// File: rtl/ycc422_pkg.sv
package ycc422_pkg;

  typedef struct packed {
    logic [7:0] y;
    logic [7:0] cb;
    logic [7:0] cr;
  } ycc_t;

  function automatic logic [7:0] clamp_luma(input logic [7:0] v);
    if (v < 8'd16)       return 8'd16;
    else if (v > 8'd235) return 8'd235;
    else                 return v;
  endfunction

  function automatic logic [7:0] clamp_chroma(input logic [7:0] v);
    if (v < 8'd16)       return 8'd16;
    else if (v > 8'd240) return 8'd240;
    else                 return v;
  endfunction

  function automatic ycc_t bar_colour(input logic [2:0] idx);
    case (idx)
      3'd0:    return '{y: 8'd235, cb: 8'd128, cr: 8'd128};
      3'd1:    return '{y: 8'd162, cb: 8'd44,  cr: 8'd142};
      3'd2:    return '{y: 8'd131, cb: 8'd156, cr: 8'd44};
      3'd3:    return '{y: 8'd112, cb: 8'd72,  cr: 8'd58};
      3'd4:    return '{y: 8'd84,  cb: 8'd184, cr: 8'd198};
      3'd5:    return '{y: 8'd65,  cb: 8'd100, cr: 8'd212};
      3'd6:    return '{y: 8'd35,  cb: 8'd212, cr: 8'd114};
      default: return '{y: 8'd16,  cb: 8'd128, cr: 8'd128};
    endcase
  endfunction

  function automatic logic signed [8:0] remove_offset(input logic [7:0] v);
    return $signed({1'b0, v}) - 9'sd128;
  endfunction

  function automatic logic [7:0] round_avg(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b} + 9'd1;
    return s[8:1];
  endfunction

endpackage

// File: rtl/ycc422_byte_capture.sv
module ycc422_byte_capture
  import ycc422_pkg::*;
#(
  parameter int ACTIVE_PIX = 720
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hsync_n,
  input  logic [7:0] pix_in,
  input  logic       cb_cr_swap,
  input  logic       luma_chroma_swap,
  input  logic       bar_mode,
  output logic       grp_valid,
  output logic       grp_last,
  output logic [7:0] grp_y0,
  output logic [7:0] grp_y1,
  output logic [7:0] grp_cb,
  output logic [7:0] grp_cr
);
  localparam int LINE_BYTES = 2 * ACTIVE_PIX;
  localparam int IDX_W      = $clog2(LINE_BYTES);
  localparam int BAR_GROUPS = ACTIVE_PIX / 16;
  localparam int BG_W       = $clog2(BAR_GROUPS + 1);

  logic             hs_q;
  logic             run;
  logic [IDX_W-1:0] byte_idx;
  logic [7:0]       b0, b1, b2;
  logic [BG_W-1:0]  bar_grp;
  logic [2:0]       bar_sel;

  logic [7:0] raw_y0, raw_y1, raw_ca, raw_cb_slot;
  logic [7:0] dec_cb, dec_cr;
  ycc_t       bar_px;
  logic       line_fall;

  assign line_fall = hs_q && !hsync_n;

  // Slot decode for the completed group (positions 0..2 held, 3 on the bus).
  always_comb begin
    if (luma_chroma_swap) begin
      raw_y0      = b0;
      raw_ca      = b1;
      raw_y1      = b2;
      raw_cb_slot = pix_in;
    end else begin
      raw_ca      = b0;
      raw_y0      = b1;
      raw_cb_slot = b2;
      raw_y1      = pix_in;
    end
    dec_cb = cb_cr_swap ? raw_cb_slot : raw_ca;
    dec_cr = cb_cr_swap ? raw_ca      : raw_cb_slot;
    bar_px = bar_colour(bar_sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q      <= 1'b0;
      run       <= 1'b0;
      byte_idx  <= '0;
      b0        <= '0;
      b1        <= '0;
      b2        <= '0;
      bar_grp   <= '0;
      bar_sel   <= '0;
      grp_valid <= 1'b0;
      grp_last  <= 1'b0;
      grp_y0    <= '0;
      grp_y1    <= '0;
      grp_cb    <= '0;
      grp_cr    <= '0;
    end else begin
      hs_q      <= hsync_n;
      grp_valid <= 1'b0;
      if (line_fall) begin
        run      <= 1'b1;
        byte_idx <= '0;
        bar_grp  <= '0;
        bar_sel  <= '0;
      end else if (run) begin
        byte_idx <= byte_idx + 1'b1;
        if (byte_idx == IDX_W'(LINE_BYTES - 1)) run <= 1'b0;
        case (byte_idx[1:0])
          2'd0: b0 <= pix_in;
          2'd1: b1 <= pix_in;
          2'd2: b2 <= pix_in;
          default: begin
            grp_valid <= 1'b1;
            grp_last  <= (byte_idx == IDX_W'(LINE_BYTES - 1));
            if (bar_mode) begin
              grp_y0 <= bar_px.y;
              grp_y1 <= bar_px.y;
              grp_cb <= bar_px.cb;
              grp_cr <= bar_px.cr;
            end else begin
              grp_y0 <= clamp_luma(raw_y0);
              grp_y1 <= clamp_luma(raw_y1);
              grp_cb <= clamp_chroma(dec_cb);
              grp_cr <= clamp_chroma(dec_cr);
            end
            if (bar_grp == BG_W'(BAR_GROUPS - 1)) begin
              bar_grp <= '0;
              bar_sel <= bar_sel + 1'b1;
            end else begin
              bar_grp <= bar_grp + 1'b1;
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/ycc422_chroma_interp.sv
module ycc422_chroma_interp
  import ycc422_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              grp_valid,
  input  logic              grp_last,
  input  logic [7:0]        grp_y0,
  input  logic [7:0]        grp_y1,
  input  logic [7:0]        grp_cb,
  input  logic [7:0]        grp_cr,
  output logic              out_valid,
  output logic [7:0]        out_y,
  output logic signed [8:0] out_cb,
  output logic signed [8:0] out_cr
);
  logic              pend_v;
  logic [7:0]        p_y0, p_y1, p_cb, p_cr;
  logic [2:0]        flush_cnt;
  logic [1:0]        odd_cnt;
  logic [7:0]        h_y1;
  logic signed [8:0] h_cb, h_cr;

  logic       emit_flush, emit_grp, emit;
  logic [7:0] nxt_cb, nxt_cr;

  always_comb begin
    emit_flush = (flush_cnt == 3'd1);
    emit_grp   = grp_valid && pend_v && !emit_flush;
    emit       = emit_flush || emit_grp;
    nxt_cb     = emit_grp ? grp_cb : p_cb;
    nxt_cr     = emit_grp ? grp_cr : p_cr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v    <= 1'b0;
      p_y0      <= '0;
      p_y1      <= '0;
      p_cb      <= '0;
      p_cr      <= '0;
      flush_cnt <= '0;
      odd_cnt   <= '0;
      h_y1      <= '0;
      h_cb      <= '0;
      h_cr      <= '0;
      out_valid <= 1'b0;
      out_y     <= '0;
      out_cb    <= '0;
      out_cr    <= '0;
    end else begin
      out_valid <= 1'b0;
      if (flush_cnt != 3'd0) flush_cnt <= flush_cnt - 1'b1;
      if (odd_cnt != 2'd0) odd_cnt <= odd_cnt - 1'b1;

      if (emit) begin
        out_valid <= 1'b1;
        out_y     <= p_y0;
        out_cb    <= remove_offset(p_cb);
        out_cr    <= remove_offset(p_cr);
        h_y1      <= p_y1;
        h_cb      <= remove_offset(round_avg(p_cb, nxt_cb));
        h_cr      <= remove_offset(round_avg(p_cr, nxt_cr));
        odd_cnt   <= 2'd2;
      end else if (odd_cnt == 2'd1) begin
        out_valid <= 1'b1;
        out_y     <= h_y1;
        out_cb    <= h_cb;
        out_cr    <= h_cr;
      end

      if (grp_valid) begin
        pend_v <= 1'b1;
        p_y0   <= grp_y0;
        p_y1   <= grp_y1;
        p_cb   <= grp_cb;
        p_cr   <= grp_cr;
        if (grp_last) flush_cnt <= 3'd4;
      end else if (emit_flush) begin
        pend_v <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ycc422_demux.sv
module ycc422_demux #(
  parameter int ACTIVE_PIX = 720
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsync_n,
  input  logic [7:0]        pix_in,
  input  logic              cb_cr_swap,
  input  logic              luma_chroma_swap,
  input  logic              bar_mode,
  output logic              out_valid,
  output logic [7:0]        out_y,
  output logic signed [8:0] out_cb,
  output logic signed [8:0] out_cr
);
  logic       grp_valid, grp_last;
  logic [7:0] grp_y0, grp_y1, grp_cb, grp_cr;

  ycc422_byte_capture #(.ACTIVE_PIX(ACTIVE_PIX)) u_capture (
    .clk              (clk),
    .rst              (rst),
    .hsync_n          (hsync_n),
    .pix_in           (pix_in),
    .cb_cr_swap       (cb_cr_swap),
    .luma_chroma_swap (luma_chroma_swap),
    .bar_mode         (bar_mode),
    .grp_valid        (grp_valid),
    .grp_last         (grp_last),
    .grp_y0           (grp_y0),
    .grp_y1           (grp_y1),
    .grp_cb           (grp_cb),
    .grp_cr           (grp_cr)
  );

  ycc422_chroma_interp u_interp (
    .clk       (clk),
    .rst       (rst),
    .grp_valid (grp_valid),
    .grp_last  (grp_last),
    .grp_y0    (grp_y0),
    .grp_y1    (grp_y1),
    .grp_cb    (grp_cb),
    .grp_cr    (grp_cr),
    .out_valid (out_valid),
    .out_y     (out_y),
    .out_cb    (out_cb),
    .out_cr    (out_cr)
  );

endmodule

// File: rtl/ycc422_demux_checker.sv
module ycc422_demux_checker (
  input logic              clk,
  input logic              rst,
  input logic              out_valid,
  input logic [7:0]        out_y,
  input logic signed [8:0] out_cb,
  input logic signed [8:0] out_cr
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_y == 8'd0 && out_cb == 9'sd0 && out_cr == 9'sd0));

  assert_strobe_spacing_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_luma_range_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_y >= 8'd16 && out_y <= 8'd235));

  assert_chroma_range_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_cb >= -9'sd112 && out_cb <= 9'sd112 &&
                   out_cr >= -9'sd112 && out_cr <= 9'sd112));
endmodule

bind ycc422_demux ycc422_demux_checker u_checker (
  .clk       (clk),
  .rst       (rst),
  .out_valid (out_valid),
  .out_y     (out_y),
  .out_cb    (out_cb),
  .out_cr    (out_cr)
);

// File: tb/ycc422_demux_test.sv
`timescale 1ns/1ps
module ycc422_demux_test;
  localparam int A = 64;
  localparam int NB = 2 * A;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              hsync_n = 1'b1;
  logic [7:0]        pix_in = 8'd0;
  logic              cb_cr_swap = 1'b0;
  logic              luma_chroma_swap = 1'b0;
  logic              bar_mode = 1'b0;
  logic              out_valid;
  logic [7:0]        out_y;
  logic signed [8:0] out_cb, out_cr;

  int compared = 0;
  int mismatched = 0;
  int got = 0;
  logic prev_valid = 1'b0;
  int cycles = 0;

  logic [7:0] bytes_a [NB];
  int exp_y [A];
  int exp_cb [A];
  int exp_cr [A];
  int got_y [A];
  int got_cb [A];
  int got_cr [A];

  always #2.5 clk = ~clk;

  ycc422_demux #(.ACTIVE_PIX(A)) uut (
    .clk(clk), .rst(rst), .hsync_n(hsync_n), .pix_in(pix_in),
    .cb_cr_swap(cb_cr_swap), .luma_chroma_swap(luma_chroma_swap),
    .bar_mode(bar_mode), .out_valid(out_valid), .out_y(out_y),
    .out_cb(out_cb), .out_cr(out_cr)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      if (out_valid && prev_valid) check("R9", "back-to-back strobe", 1, 0);
      if (out_valid) begin
        if (got < A) begin
          got_y[got]  = out_y;
          got_cb[got] = out_cb;
          got_cr[got] = out_cr;
        end
        got++;
      end
    end
    prev_valid = out_valid;
  end

  initial begin
    #400000;
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  function automatic int cl_y(input int v);
    return v < 16 ? 16 : (v > 235 ? 235 : v);
  endfunction
  function automatic int cl_c(input int v);
    return v < 16 ? 16 : (v > 240 ? 240 : v);
  endfunction

  function automatic void bar_val(input int k, output int y, output int cb, output int cr);
    case (k)
      0: begin y = 235; cb = 128; cr = 128; end
      1: begin y = 162; cb = 44;  cr = 142; end
      2: begin y = 131; cb = 156; cr = 44;  end
      3: begin y = 112; cb = 72;  cr = 58;  end
      4: begin y = 84;  cb = 184; cr = 198; end
      5: begin y = 65;  cb = 100; cr = 212; end
      6: begin y = 35;  cb = 212; cr = 114; end
      default: begin y = 16; cb = 128; cr = 128; end
    endcase
  endfunction

  // Expected samples from R3..R8, R10
  task automatic build_expect(input logic cbs, input logic ycs, input logic bar);
    int gcb [A/2];
    int gcr [A/2];
    for (int g = 0; g < A/2; g++) begin
      int p0, p1, p2, p3, ya, yb, ca, cbb, cbv, crv;
      p0 = bytes_a[4*g]; p1 = bytes_a[4*g+1];
      p2 = bytes_a[4*g+2]; p3 = bytes_a[4*g+3];
      if (bar) begin
        bar_val((2*g) / (A/8), ya, cbv, crv);
        yb = ya;
      end else begin
        if (ycs) begin ya = p0; ca = p1; yb = p2; cbb = p3; end
        else     begin ca = p0; ya = p1; cbb = p2; yb = p3; end
        cbv = cbs ? cbb : ca;
        crv = cbs ? ca : cbb;
        ya = cl_y(ya); yb = cl_y(yb); cbv = cl_c(cbv); crv = cl_c(crv);
      end
      exp_y[2*g] = ya; exp_y[2*g+1] = yb;
      gcb[g] = cbv; gcr[g] = crv;
    end
    for (int g = 0; g < A/2; g++) begin
      int ng;
      ng = (g == A/2 - 1) ? g : g + 1;
      exp_cb[2*g]   = gcb[g] - 128;
      exp_cr[2*g]   = gcr[g] - 128;
      exp_cb[2*g+1] = ((gcb[g] + gcb[ng] + 1) / 2) - 128;
      exp_cr[2*g+1] = ((gcr[g] + gcr[ng] + 1) / 2) - 128;
    end
  endtask

  task automatic run_line(input logic cbs, input logic ycs, input logic bar, input string req);
    @(negedge clk);
    cb_cr_swap = cbs; luma_chroma_swap = ycs; bar_mode = bar;
    hsync_n = 1'b1;
    repeat (3) @(negedge clk);
    got = 0;
    build_expect(cbs, ycs, bar);
    hsync_n = 1'b0;
    for (int i = 0; i < NB; i++) begin
      @(negedge clk);
      pix_in = bytes_a[i];
    end
    // extra bytes after the line end, hsync still low: ignored (R2)
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      pix_in = 8'(i * 53 + 7);
    end
    repeat (12) @(negedge clk);
    check("R9", {req, " sample count"}, got, A);
    for (int s = 0; s < A; s++) begin
      check(req, "luma", got_y[s], exp_y[s]);
      check(req, "cb", got_cb[s], exp_cb[s]);
      check(req, "cr", got_cr[s], exp_cr[s]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "valid in reset", out_valid, 0);
    check("R1", "luma in reset", out_y, 0);
    check("R1", "cb in reset", out_cb, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "valid after reset", out_valid, 0);

    // no line start while hsync_n is high: bytes ignored (R2)
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      pix_in = 8'(i);
    end
    check("R2", "samples without sync", got, 0);

    // Sweep every byte value into luma and chroma slots under all swap settings
    for (int m = 0; m < 4; m++) begin
      for (int l = 0; l < 4; l++) begin
        for (int i = 0; i < NB; i++) bytes_a[i] = 8'((i >> 1) + 64 * l);
        case (m)
          0: run_line(1'b0, 1'b0, 1'b0, "R3_R6_R7_R8");
          1: run_line(1'b1, 1'b0, 1'b0, "R4_R6_R7_R8");
          2: run_line(1'b0, 1'b1, 1'b0, "R5_R6_R7_R8");
          default: run_line(1'b1, 1'b1, 1'b0, "R4_R5_R8");
        endcase
      end
    end

    // Irregular pattern for chroma averaging with distinct neighbours
    for (int i = 0; i < NB; i++) bytes_a[i] = 8'((i * 97 + 13) % 256);
    run_line(1'b0, 1'b0, 1'b0, "R8");

    // Colour bars with garbage on the bus
    for (int i = 0; i < NB; i++) bytes_a[i] = 8'((i * 151 + 3) % 256);
    run_line(1'b0, 1'b0, 1'b1, "R10");
    run_line(1'b1, 1'b1, 1'b1, "R10");
    bar_mode = 1'b0;

    // hsync_n held low after a line: no new line (R2)
    got = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      pix_in = 8'(i * 7);
    end
    check("R2", "samples with hsync held low", got, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule